// File: doc/BRIEF.md
# Dual-Write-Port Register File

This block is the general-purpose register storage of a small processor datapath. It holds a set of word-wide registers. Two read ports look up registers combinationally, and two write ports can both update the array on the same rising clock edge. Register zero is fixed: any read of it returns zero, and any write aimed at it is dropped.

The two write ports must never target the same nonzero register in the same cycle. If that happens anyway, the block resolves it deterministically and reports it. Write port A takes priority, so only its data is stored. A conflict flag is raised for one cycle after the offending edge. The block has no bypass: a read of a register that is being written in the same cycle returns the stored value until the edge, and the new value after it.

Top module: `dwrf_top`

## Requirements
- R1: Each read data output shows the stored value of the register selected by its read address with no clock delay, and reading address 0 on either port gives 0.
- R2: When write enable A is high at a rising clock edge and write address A is nonzero, that register holds write data A after the edge. When write enable A is low, nothing changes.
- R3: When write enable B is high at a rising clock edge, write address B is nonzero, and port A is not writing the same register, that register holds write data B after the edge. When write enable B is low, nothing changes.
- R4: Enabled writes on both ports to two different nonzero registers are both committed on the same edge.
- R5: Writes to address 0 from either port are discarded, and address 0 continues to read as 0.
- R6: When both read addresses equal an enabled write address, both read outputs give the old stored value before the edge and the written value after it. There is no forwarding.
- R7: When both write enables are high with equal nonzero addresses, only write data A is stored in that register.
- R8: The conflict output is high during the cycle after a rising edge at which both write enables were high with equal nonzero addresses, and is low after every other edge. Two enabled writes that both target address 0 are not a conflict.
- R9: While the active-low reset is asserted, the conflict output is 0. Reset does not initialise the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the conflict flag |
| rd_a_addr_i | input | 5 | Register selected by read port A |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 5 | Register selected by read port B |
| rd_b_data_o | output | 32 | Read port B data |
| wr_a_en_i | input | 1 | Write enable, port A (priority port) |
| wr_a_addr_i | input | 5 | Write register, port A |
| wr_a_data_i | input | 32 | Write data, port A |
| wr_b_en_i | input | 1 | Write enable, port B |
| wr_b_addr_i | input | 5 | Write register, port B |
| wr_b_data_i | input | 32 | Write data, port B |
| conflict_o | output | 1 | High for one cycle after a same-register double write |

## Verification
The properties assume that the write enables and addresses are known, non-X values at every rising edge after reset. They also assume that read data is compared only for registers that have been written since power-up, because reset leaves the array undefined. The stimulus meets this by filling every register through both ports before any comparison of unwritten contents is made. The stimulus changes inputs only on the falling edge. Same-register double writes are created on purpose, both in directed cases and at a low random rate, so that the priority rule and the flag are exercised without dominating the traffic.

// File: rtl/dwrf_pkg.sv
package dwrf_pkg;
    localparam int unsigned RF_DEPTH = 32;
    localparam int unsigned RF_WIDTH = 32;

    // one-hot style decode of an enabled address against a register index
    function automatic logic addr_hit(input logic en, input logic [7:0] addr, input int unsigned idx);
        return en && (32'(addr) == idx);
    endfunction
endpackage

// File: rtl/dwrf_wr_arbiter.sv
module dwrf_wr_arbiter #(
    parameter int unsigned NUM_REGS = 32,
    localparam int unsigned ADDR_W = $clog2(NUM_REGS)
) (
    input  logic                  en_a_i,
    input  logic [ADDR_W-1:0]     addr_a_i,
    input  logic                  en_b_i,
    input  logic [ADDR_W-1:0]     addr_b_i,
    output logic [NUM_REGS-1:1]   take_a_o,
    output logic [NUM_REGS-1:1]   take_b_o,
    output logic                  clash_o
);
    logic [7:0] addr_a_w;
    logic [7:0] addr_b_w;

    assign addr_a_w = 8'(addr_a_i);
    assign addr_b_w = 8'(addr_b_i);

    // per-register decode; port A wins a shared target
    for (genvar i = 1; i < NUM_REGS; i++) begin : g_dec
        logic hit_a;
        logic hit_b;
        assign hit_a       = dwrf_pkg::addr_hit(en_a_i, addr_a_w, i);
        assign hit_b       = dwrf_pkg::addr_hit(en_b_i, addr_b_w, i);
        assign take_a_o[i] = hit_a;
        assign take_b_o[i] = hit_b && !hit_a;
    end

    assign clash_o = en_a_i && en_b_i && (addr_a_i == addr_b_i) && (addr_a_i != '0);
endmodule

// File: rtl/dwrf_rd_port.sv
module dwrf_rd_port #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:1][DATA_W-1:0] regs_i,
    input  logic [ADDR_W-1:0]               addr_i,
    output logic [DATA_W-1:0]               data_o
);
    // register zero has no storage: the default zero covers it
    always_comb begin
        data_o = '0;
        for (int i = 1; i < NUM_REGS; i++) begin
            if (addr_i == ADDR_W'(i)) begin
                data_o = regs_i[i];
            end
        end
    end
endmodule

// File: rtl/dwrf_top.sv
module dwrf_top #(
    parameter int unsigned NUM_REGS = dwrf_pkg::RF_DEPTH,
    parameter int unsigned DATA_W   = dwrf_pkg::RF_WIDTH,
    localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_a_addr_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [ADDR_W-1:0] rd_b_addr_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_a_en_i,
    input  logic [ADDR_W-1:0] wr_a_addr_i,
    input  logic [DATA_W-1:0] wr_a_data_i,
    input  logic              wr_b_en_i,
    input  logic [ADDR_W-1:0] wr_b_addr_i,
    input  logic [DATA_W-1:0] wr_b_data_i,
    output logic              conflict_o
);
    typedef struct packed {
        logic [NUM_REGS-1:1][DATA_W-1:0] regs;
        logic                            conflict;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic [NUM_REGS-1:1] take_a;
    logic [NUM_REGS-1:1] take_b;
    logic                clash;

    dwrf_wr_arbiter #(.NUM_REGS(NUM_REGS)) u_arb (
        .en_a_i   (wr_a_en_i),
        .addr_a_i (wr_a_addr_i),
        .en_b_i   (wr_b_en_i),
        .addr_b_i (wr_b_addr_i),
        .take_a_o (take_a),
        .take_b_o (take_b),
        .clash_o  (clash)
    );

    always_comb begin
        state_d          = state_q;
        state_d.conflict = clash;
        for (int i = 1; i < NUM_REGS; i++) begin
            if (take_a[i]) begin
                state_d.regs[i] = wr_a_data_i;
            end else if (take_b[i]) begin
                state_d.regs[i] = wr_b_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.conflict <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    dwrf_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_a (
        .regs_i (state_q.regs),
        .addr_i (rd_a_addr_i),
        .data_o (rd_a_data_o)
    );

    dwrf_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_b (
        .regs_i (state_q.regs),
        .addr_i (rd_b_addr_i),
        .data_o (rd_b_data_o)
    );

    assign conflict_o = state_q.conflict;
endmodule

// File: rtl/dwrf_checker.sv
module dwrf_checker #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [ADDR_W-1:0]               rd_a_addr_i,
    input logic [DATA_W-1:0]               rd_a_data_o,
    input logic [ADDR_W-1:0]               rd_b_addr_i,
    input logic [DATA_W-1:0]               rd_b_data_o,
    input logic                            wr_a_en_i,
    input logic [ADDR_W-1:0]               wr_a_addr_i,
    input logic [DATA_W-1:0]               wr_a_data_i,
    input logic                            wr_b_en_i,
    input logic [ADDR_W-1:0]               wr_b_addr_i,
    input logic [DATA_W-1:0]               wr_b_data_i,
    input logic                            conflict_o,
    input logic [NUM_REGS-1:1][DATA_W-1:0] regs_q
);
    logic same_nz;
    assign same_nz = wr_a_en_i && wr_b_en_i && (wr_a_addr_i == wr_b_addr_i) && (wr_a_addr_i != '0);

    // R1
    zero_read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr_i == '0) |-> (rd_a_data_o == '0));
    // R1
    zero_read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_addr_i == '0) |-> (rd_b_data_o == '0));
    // R2
    port_a_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a_en_i && wr_a_addr_i != '0) |=> (regs_q[$past(wr_a_addr_i)] == $past(wr_a_data_i)));
    // R3
    port_b_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b_en_i && wr_b_addr_i != '0 && !(wr_a_en_i && wr_a_addr_i == wr_b_addr_i))
        |=> (regs_q[$past(wr_b_addr_i)] == $past(wr_b_data_i)));
    // R6
    no_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a_en_i && wr_a_addr_i != '0 && rd_a_addr_i == wr_a_addr_i && rd_b_addr_i == wr_a_addr_i)
        |-> (rd_a_data_o == regs_q[wr_a_addr_i] && rd_b_data_o == rd_a_data_o));
    // R8
    flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        same_nz |=> conflict_o);
    // R8
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !same_nz |=> !conflict_o);
    // R9
    always_comb begin
        if (!rst_n) begin
            reset_flag_chk: assert (!conflict_o);
        end
    end
endmodule

bind dwrf_top dwrf_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a_addr_i (rd_a_addr_i),
    .rd_a_data_o (rd_a_data_o),
    .rd_b_addr_i (rd_b_addr_i),
    .rd_b_data_o (rd_b_data_o),
    .wr_a_en_i   (wr_a_en_i),
    .wr_a_addr_i (wr_a_addr_i),
    .wr_a_data_i (wr_a_data_i),
    .wr_b_en_i   (wr_b_en_i),
    .wr_b_addr_i (wr_b_addr_i),
    .wr_b_data_i (wr_b_data_i),
    .conflict_o  (conflict_o),
    .regs_q      (state_q.regs)
);

// File: tb/tb_dwrf_top.sv
module tb_dwrf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ra_a = '0, ra_b = '0, wa_a = '0, wa_b = '0;
    logic [31:0] wd_a = '0, wd_b = '0;
    logic        we_a = 1'b0, we_b = 1'b0;
    logic [31:0] rdat_a, rdat_b;
    logic        conf;

    int          errors = 0;
    int          checks = 0;
    logic [31:0] model [32];
    bit          known [32];
    bit          model_conf = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dwrf_top dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr_i(ra_a), .rd_a_data_o(rdat_a),
        .rd_b_addr_i(ra_b), .rd_b_data_o(rdat_b),
        .wr_a_en_i(we_a), .wr_a_addr_i(wa_a), .wr_a_data_i(wd_a),
        .wr_b_en_i(we_b), .wr_b_addr_i(wa_b), .wr_b_data_i(wd_b),
        .conflict_o(conf)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every output with the model (reads only for known registers)
    task automatic compare(input string tag);
        if (known[ra_a]) check({tag, " port A read"}, rdat_a, model[ra_a]);
        if (known[ra_b]) check({tag, " port B read"}, rdat_b, model[ra_b]);
        check({tag, " R8 flag"}, 32'(conf), 32'(model_conf));
    endtask

    // drive after a falling edge, compare mid-low phase, advance the model at the rising edge
    task automatic step(input string tag,
                        input logic ea, input logic [4:0] aa, input logic [31:0] da,
                        input logic eb, input logic [4:0] ab, input logic [31:0] db,
                        input logic [4:0] qa, input logic [4:0] qb);
        we_a = ea; wa_a = aa; wd_a = da;
        we_b = eb; wa_b = ab; wd_b = db;
        ra_a = qa; ra_b = qb;
        #5;
        compare(tag);
        @(posedge clk);
        model_conf = ea && eb && (aa == ab) && (aa != 0);
        if (eb && ab != 0 && !(ea && aa == ab)) begin model[ab] = db; known[ab] = 1'b1; end
        if (ea && aa != 0) begin model[aa] = da; known[aa] = 1'b1; end
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin model[i] = '0; known[i] = (i == 0); end
        // R9 / R1: reset state
        @(negedge clk);
        #3;
        check("R9 flag in reset", 32'(conf), 32'd0);
        check("R1 addr0 port A in reset", rdat_a, 32'd0);
        check("R1 addr0 port B in reset", rdat_b, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: fill every register, two distinct ones per edge
        for (int i = 1; i < 32; i += 2) begin
            step("R4 fill", 1'b1, 5'(i), 32'hA000_0000 + 32'(i),
                 (i + 1 < 32), 5'((i + 1) % 32), 32'hB000_0000 + 32'(i + 1), 5'(i), 5'((i + 1) % 32));
        end
        // R1: read back every location on both ports
        for (int i = 0; i < 32; i++) begin
            step("R1 readback", 1'b0, '0, '0, 1'b0, '0, '0, 5'(i), 5'(31 - i));
        end
        // R2 R3: disabled ports carry data but change nothing
        step("R2 R3 disabled", 1'b0, 5'd7, 32'hDEAD_0007, 1'b0, 5'd8, 32'hDEAD_0008, 5'd7, 5'd8);
        step("R2 R3 after disabled", 1'b0, '0, '0, 1'b0, '0, '0, 5'd7, 5'd8);
        // R6: both reads on port A's write target
        step("R6 port A before edge", 1'b1, 5'd9, 32'h1111_2222, 1'b0, '0, '0, 5'd9, 5'd9);
        step("R6 port A after edge", 1'b0, '0, '0, 1'b0, '0, '0, 5'd9, 5'd9);
        // R6: both reads on port B's write target
        step("R6 port B before edge", 1'b0, '0, '0, 1'b1, 5'd20, 32'h3333_4444, 5'd20, 5'd20);
        step("R6 port B after edge", 1'b0, '0, '0, 1'b0, '0, '0, 5'd20, 5'd20);
        // R7 R8: double write, port A wins, flag for one cycle
        step("R7 conflict issue", 1'b1, 5'd15, 32'h5555_AAAA, 1'b1, 5'd15, 32'h6666_BBBB, 5'd15, 5'd15);
        step("R7 R8 conflict result", 1'b0, '0, '0, 1'b0, '0, '0, 5'd15, 5'd15);
        check("R7 stored data", rdat_a, 32'h5555_AAAA);
        step("R8 flag dropped", 1'b0, '0, '0, 1'b0, '0, '0, 5'd15, 5'd0);
        // R5 R8: both ports aimed at register zero
        step("R5 zero writes", 1'b1, 5'd0, 32'hFFFF_FFFF, 1'b1, 5'd0, 32'hEEEE_EEEE, 5'd0, 5'd0);
        step("R5 after zero writes", 1'b0, '0, '0, 1'b0, '0, '0, 5'd0, 5'd0);
        check("R5 addr0 stays zero", rdat_b, 32'd0);
        check("R8 no flag for addr0", 32'(conf), 32'd0);
        // mixed random traffic, occasional double writes (R7)
        for (int n = 0; n < 400; n++) begin
            logic [4:0] a1, a2;
            a1 = 5'($urandom_range(0, 31));
            a2 = ($urandom_range(0, 19) == 0) ? a1 : 5'($urandom_range(0, 31));
            step("R7 random", 1'($urandom_range(0, 1)), a1, $urandom,
                 1'($urandom_range(0, 1)), a2, $urandom,
                 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule